// File: doc/BRIEF.md
# Secondary Interrupt Controller with Line Passthrough

This block gathers 32 level-sensitive interrupt lines and produces 32 output lines for a primary interrupt controller. It keeps a register that holds the current level of each input. An enable mask selects which of those levels count toward a single combined interrupt, and that combined interrupt drives output line 31. A separate passthrough register lets inputs 21 to 30 skip the combined path. A line with its passthrough bit set drives the output line with the same number directly, so the primary controller sees it on its own.

Software reaches the block through a 4 KB window of 32-bit words on a simple select/write-enable bus. The word index is the byte address shifted right by two. The mask and the passthrough register are never written directly. Software sets bits through one word index and clears them through another, so two drivers that share the block cannot undo each other's bits. Mask bit 0 also has its own set and clear words, which act only on a nonzero write.

Top module: `sic_top`

## Requirements
- R1: The raw level register captures `irq_i` on every clock edge. Reading word index 1 returns it.
- R2: Output line 31 is high exactly when the raw level AND the enable mask is nonzero. Reading word index 0 returns raw level AND mask.
- R3: Reading index 2 returns the mask. Reading index 4 returns raw level bit 0 in bit 0, with all other bits zero. Reading index 8 returns the passthrough register. Reading any other index returns zero.
- R4: A write to index 2 ORs the data into the mask. A write to index 3 clears every mask bit that is written as one.
- R5: A nonzero write to index 4 sets mask bit 0, and a nonzero write to index 5 clears it. Writing zero to either index leaves the mask unchanged.
- R6: A write to index 8 ORs in only the data bits 21 to 30 (value 0x7FE00000) into the passthrough register. A write to index 9 clears every passthrough bit that is written as one.
- R7: For each line from 21 to 30 whose passthrough bit is set, the output line with that number equals raw level bit i. This also holds for a level that was already present when the passthrough bit was set.
- R8: Output lines 0 to 30 whose passthrough bit is clear are low. Clearing a passthrough bit drives its output low.
- R9: A write to any index other than 2, 3, 4, 5, 8 or 9 changes no state. Address bits 1:0 play no part in decoding.
- R10: Reset, active low and asynchronous, clears raw level, mask, passthrough register, outputs and read data.
- R11: A register write takes effect at the edge where it is sampled, and the outputs follow one edge later. An input change reaches the outputs two edges after it is applied. Read data appears one edge after the read is sampled and is zero in cycles with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address within the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_i | input | 32 | Level interrupt inputs |
| irq_o | output | 32 | Lines to primary controller; bit 31 is the combined interrupt |

## Verification
A corrupted mask or passthrough bit shows on `irq_o` on the edge after the write. It also shows on readback of index 2 or 8 one cycle after the read. A stale raw level bit shows on the output two edges after the input changes, and on an index 1 read. The bench drives each input line alone through every mask and passthrough state. It then runs pseudo-random sequences of levels and writes. At each step it compares the outputs and the readback with a model of the register semantics computed in the bench.

// File: rtl/sic_pkg.sv
package sic_pkg;
  // word indexes; their values are the bus map
  localparam int IDX_STATUS  = 0;
  localparam int IDX_RAW     = 1;
  localparam int IDX_MASK    = 2;  // read mask / write OR-set
  localparam int IDX_MCLR    = 3;
  localparam int IDX_SOFT    = 4;  // read level[0] / write sets mask[0]
  localparam int IDX_SOFTCLR = 5;
  localparam int IDX_PT      = 8;  // read pt / write OR-set (restricted)
  localparam int IDX_PTCLR   = 9;
endpackage

// File: rtl/sic_level.sv
module sic_level #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] irq_i,
  output logic [N-1:0] level_o
);
  logic [N-1:0] level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= '0;
    else         level_q <= irq_i;
  end

  assign level_o = level_q;

  assert_level_track_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (level_o == $past(irq_i)));
endmodule

// File: rtl/sic_regs.sv
module sic_regs #(
  parameter int N      = 32,
  parameter int ADDR_W = 12,
  parameter int PT_LO  = 21,
  parameter int PT_HI  = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  input  logic [N-1:0]      level_i,
  output logic [N-1:0]      rdata_o,
  output logic [N-1:0]      mask_o,
  output logic [N-1:0]      pt_o
);
  import sic_pkg::*;

  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] I_STAT = IDX_W'(IDX_STATUS);
  localparam logic [IDX_W-1:0] I_RAW  = IDX_W'(IDX_RAW);
  localparam logic [IDX_W-1:0] I_MSET = IDX_W'(IDX_MASK);
  localparam logic [IDX_W-1:0] I_MCLR = IDX_W'(IDX_MCLR);
  localparam logic [IDX_W-1:0] I_SSET = IDX_W'(IDX_SOFT);
  localparam logic [IDX_W-1:0] I_SCLR = IDX_W'(IDX_SOFTCLR);
  localparam logic [IDX_W-1:0] I_PSET = IDX_W'(IDX_PT);
  localparam logic [IDX_W-1:0] I_PCLR = IDX_W'(IDX_PTCLR);

  function automatic logic [N-1:0] pt_allow_f();
    logic [N-1:0] m;
    for (int k = 0; k < N; k++) m[k] = (k >= PT_LO) && (k <= PT_HI);
    return m;
  endfunction
  localparam logic [N-1:0] PT_ALLOW = pt_allow_f();
  localparam logic [N-1:0] BIT0     = N'(1);

  logic [IDX_W-1:0] idx;
  logic             wr, rd, wnz, wr_known;
  logic [N-1:0]     mask_q, mask_d, pt_q, pt_d, rd_val, rdata_q;

  assign idx = addr_i[ADDR_W-1:2];
  assign wr  = sel_i && we_i;
  assign rd  = sel_i && !we_i;
  assign wnz = |wdata_i;

  always_comb begin
    mask_d   = mask_q;
    pt_d     = pt_q;
    wr_known = 1'b0;
    if (wr) begin
      unique case (idx)
        I_MSET: begin mask_d = mask_q | wdata_i;          wr_known = 1'b1; end
        I_MCLR: begin mask_d = mask_q & ~wdata_i;         wr_known = 1'b1; end
        I_SSET: begin if (wnz) mask_d = mask_q | BIT0;    wr_known = 1'b1; end
        I_SCLR: begin if (wnz) mask_d = mask_q & ~BIT0;   wr_known = 1'b1; end
        I_PSET: begin pt_d = pt_q | (wdata_i & PT_ALLOW); wr_known = 1'b1; end
        I_PCLR: begin pt_d = pt_q & ~wdata_i;             wr_known = 1'b1; end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (idx)
      I_STAT:  rd_val = level_i & mask_q;
      I_RAW:   rd_val = level_i;
      I_MSET:  rd_val = mask_q;
      I_SSET:  rd_val = {{(N-1){1'b0}}, level_i[0]};
      I_PSET:  rd_val = pt_q;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      pt_q    <= '0;
      rdata_q <= '0;
    end else begin
      mask_q  <= mask_d;
      pt_q    <= pt_d;
      rdata_q <= rd ? rd_val : '0;
    end
  end

  assign mask_o  = mask_q;
  assign pt_o    = pt_q;
  assign rdata_o = rdata_q;

  assert_mask_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && idx == I_MSET) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));
  assert_mask_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && idx == I_MCLR) |=> ((mask_q & $past(wdata_i)) == '0));
  assert_soft_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && idx == I_SCLR && wnz) |=> !mask_q[0]);
  assert_soft_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && (idx == I_SSET || idx == I_SCLR) && !wnz) |=> $stable(mask_q));
  assert_pt_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && idx == I_PCLR) |=> ((pt_q & $past(wdata_i)) == '0));
  assert_ignore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !wr_known) |=> ($stable(mask_q) && $stable(pt_q)));
  assert_rd_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> (rdata_o == '0));
endmodule

// File: rtl/sic_route.sv
module sic_route #(
  parameter int N        = 32,
  parameter int SUM_LINE = N - 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] level_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] pt_i,
  output logic [N-1:0] irq_o
);
  localparam logic [N-1:0] SUM_BIT = N'(1) << SUM_LINE;

  logic [N-1:0] out_q;

  for (genvar g = 0; g < N; g++) begin : g_line
    logic nxt;
    if (g == SUM_LINE) begin : g_sum
      assign nxt = |(level_i & mask_i);
    end else begin : g_pass
      assign nxt = pt_i[g] & level_i[g];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) out_q[g] <= 1'b0;
      else         out_q[g] <= nxt;
    end
  end

  assign irq_o = out_q;

  assert_summary_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (irq_o[SUM_LINE] == |($past(level_i) & $past(mask_i))));
  assert_pt_follow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ((irq_o & $past(pt_i) & ~SUM_BIT) ==
                       ($past(level_i) & $past(pt_i) & ~SUM_BIT)));
  assert_idle_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~SUM_BIT & ~$past(pt_i)) == '0);
endmodule

// File: rtl/sic_top.sv
module sic_top #(
  parameter int N        = 32,
  parameter int ADDR_W   = 12,
  parameter int SUM_LINE = N - 1,
  parameter int PT_LO    = 21,
  parameter int PT_HI    = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  output logic [N-1:0]      rdata_o,
  input  logic [N-1:0]      irq_i,
  output logic [N-1:0]      irq_o
);
  logic [N-1:0] level, mask, pt;

  sic_level #(.N(N)) u_level (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .level_o(level)
  );

  sic_regs #(.N(N), .ADDR_W(ADDR_W), .PT_LO(PT_LO), .PT_HI(PT_HI)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .level_i(level),
    .rdata_o(rdata_o), .mask_o(mask), .pt_o(pt)
  );

  sic_route #(.N(N), .SUM_LINE(SUM_LINE)) u_route (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_i(level), .mask_i(mask),
    .pt_i(pt), .irq_o(irq_o)
  );

  assert_reset_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> (irq_o == '0 && rdata_o == '0));
endmodule

// File: tb/sic_top_test.sv
module sic_top_test;
  logic        clk, rst_ni, sel, we;
  logic [11:0] addr;
  logic [31:0] wdata, rdata, irq_in, irq_out;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] m_lvl, m_mask, m_pt;
  localparam logic [31:0] PT_OK = 32'h7FE0_0000;

  sic_top uut (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_i(irq_in), .irq_o(irq_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(10 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: act=hung exp=done");
    summary();
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_out();
    return (m_pt & m_lvl) | ({31'b0, |(m_lvl & m_mask)} << 31);
  endfunction

  function automatic logic [31:0] exp_rd(input int idx);
    case (idx)
      0: return m_lvl & m_mask;
      1: return m_lvl;
      2: return m_mask;
      4: return {31'b0, m_lvl[0]};
      8: return m_pt;
      default: return 32'h0;
    endcase
  endfunction

  // write by byte address; state settles one edge after commit
  task automatic wr_b(input logic [11:0] ba, input logic [31:0] d);
    @(negedge clk); sel = 1; we = 1; addr = ba; wdata = d;
    @(negedge clk); sel = 0; we = 0; wdata = '0;
    case (int'(ba >> 2))
      2: m_mask |= d;
      3: m_mask &= ~d;
      4: if (d != 0) m_mask |= 32'h1;
      5: if (d != 0) m_mask &= ~32'h1;
      8: m_pt |= d & PT_OK;
      9: m_pt &= ~d;
      default: ;
    endcase
    @(negedge clk);
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    wr_b(12'(idx << 2), d);
  endtask

  task automatic rd_chk(input int idx, input string req);
    @(negedge clk); sel = 1; we = 0; addr = 12'(idx << 2);
    @(negedge clk); check(req, rdata, exp_rd(idx)); sel = 0;
  endtask

  task automatic set_irq(input logic [31:0] v);
    @(negedge clk); irq_in = v; m_lvl = v;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic out_chk(input string req);
    check(req, irq_out, exp_out());
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 0; irq_in = '0;
    m_lvl = '0; m_mask = '0; m_pt = '0;
    #1 check("R10 outputs low in reset", irq_out, 32'h0);
    @(negedge clk); @(negedge clk); rst_ni = 1;
  endtask

  function automatic logic [31:0] nxt_rand(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  initial begin
    logic [31:0] seed;
    int pick[6] = '{2, 3, 4, 5, 8, 9};
    sel = 0; we = 0; addr = '0; wdata = '0; irq_in = '0; rst_ni = 0;
    m_lvl = '0; m_mask = '0; m_pt = '0;
    do_reset();

    // R10 reset state
    @(negedge clk);
    check("R10 irq after reset", irq_out, 32'h0);
    check("R10 rdata after reset", rdata, 32'h0);
    rd_chk(1, "R10 raw cleared");
    rd_chk(2, "R10 mask cleared");
    rd_chk(8, "R10 pt cleared");

    // sweep each line through mask and passthrough states
    for (int i = 0; i < 32; i++) begin
      wr(3, '1); wr(9, '1);
      set_irq(32'h1 << i);
      out_chk("R8 masked line stays low");
      rd_chk(1, "R1 raw level single line");
      rd_chk(0, "R2 status masked off");
      wr(2, 32'h1 << i);
      out_chk("R2 summary on line 31");
      rd_chk(0, "R2 status enabled");
      rd_chk(2, "R3 mask readback");
      wr(3, '1);
      wr(8, 32'h1 << i);
      out_chk("R7 passthrough single line");
      rd_chk(8, "R6 pt only bits 21..30");
      wr(9, 32'h1 << i);
      out_chk("R8 pt cleared drives low");
      set_irq(32'h0);
      out_chk("R1 level falls");
    end

    // mask bit 0 set/clear words
    wr(3, '1); set_irq(32'h1);
    wr(4, 32'h0); rd_chk(2, "R5 zero set write ignored");
    wr(4, 32'h5); rd_chk(2, "R5 nonzero set");
    out_chk("R5 summary from bit0");
    rd_chk(4, "R3 index 4 returns level0");
    wr(5, 32'h0); rd_chk(2, "R5 zero clear write ignored");
    wr(5, 32'h80); rd_chk(2, "R5 nonzero clear");
    out_chk("R5 summary gone");

    // passthrough group
    wr(8, '1); rd_chk(8, "R6 all-ones set limited");
    set_irq(32'hAAAA_AAAA); out_chk("R7 pattern A");
    set_irq(32'h5555_5555); out_chk("R7 pattern 5");
    wr(9, 32'h00F0_0000); out_chk("R8 partial pt clear");
    rd_chk(8, "R6 partial clear readback");
    wr(9, '1);
    set_irq(32'h0200_0000); out_chk("R8 no pt no output");
    wr(8, 32'h0200_0000); out_chk("R7 re-evaluated after pt write");

    // unlisted writes and low address bits
    wr(2, 32'h0F0F_0F0F); wr(8, '1); set_irq(32'hC3C3_C3C3);
    foreach (pick[k]) ;
    for (int j = 0; j < 8; j++) begin
      int bad[8] = '{0, 1, 6, 7, 10, 11, 100, 1023};
      wr(bad[j], '1);
      rd_chk(2, "R9 mask unchanged by unlisted write");
      rd_chk(8, "R9 pt unchanged by unlisted write");
      out_chk("R9 outputs unchanged");
    end
    wr_b(12'h00F, 32'h3000_0000); rd_chk(2, "R9 low addr bits ignored");
    for (int j = 0; j < 7; j++) begin
      int unl[7] = '{3, 5, 6, 7, 9, 10, 1023};
      rd_chk(unl[j], "R3 unlisted index reads zero");
    end

    // timing
    wr(3, '1); wr(9, '1); set_irq(32'h0); wr(2, 32'h20);
    @(negedge clk); irq_in = 32'h20; m_lvl = 32'h20;
    @(negedge clk); check("R11 input not yet at output", irq_out, 32'h0);
    @(negedge clk); check("R11 input at output after two edges", irq_out, 32'h8000_0000);
    sel = 1; we = 1; addr = 12'h00C; wdata = 32'h20;
    @(negedge clk); sel = 0; we = 0; m_mask = 32'h0;
    check("R11 output holds at write edge", irq_out, 32'h8000_0000);
    @(negedge clk); check("R11 output follows one edge later", irq_out, 32'h0);
    sel = 1; we = 0; addr = 12'h004;
    @(negedge clk); sel = 0;
    check("R11 read data after one edge", rdata, 32'h20);
    @(negedge clk); check("R11 idle read data zero", rdata, 32'h0);

    // pseudo-random mix
    seed = 32'h1234_5678;
    for (int t = 0; t < 300; t++) begin
      seed = nxt_rand(seed);
      if (seed[0]) set_irq(nxt_rand(seed ^ 32'h9E37_79B9));
      seed = nxt_rand(seed);
      wr(pick[int'(seed[7:0]) % 6], nxt_rand(seed) & nxt_rand(seed + 1));
      out_chk("R2 R7 R8 random outputs");
      if (t % 10 == 0) begin
        rd_chk(0, "R2 random status");
        rd_chk(2, "R4 random mask");
        rd_chk(8, "R6 random pt");
      end
    end

    // reset mid-run
    wr(2, '1); wr(8, '1); set_irq(32'hFFFF_FFFF);
    do_reset();
    @(negedge clk);
    check("R10 outputs cleared by reset", irq_out, 32'h0);
    rd_chk(2, "R10 mask cleared by reset");
    rd_chk(8, "R10 pt cleared by reset");
    rd_chk(1, "R10 raw cleared by reset");

    summary();
  end
endmodule